// File: doc/BRIEF.md
# Interrupt Status, Enable and Clear Unit

This block sits beside a serial controller core that can run either a two-wire (I2C) or a four-wire (SPI) link. It gathers the event pulses and level conditions the core produces into one status word. Protocol events (addressed as slave, stop seen, arbitration lost, no acknowledge, repeated start) are sticky: a one-cycle pulse sets the bit, and the bit stays set until software writes a one to the same position of the clear register. All other status bits follow their source levels with one register stage of delay.

A mask register selects which status bits may raise the interrupt. The unit also reports the index of the highest-numbered bit that is both set and enabled. Because error and protocol events sit at higher positions than the buffer events, a handler that services the reported index first deals with arbitration loss and missing acknowledge before transmit-empty. A single interrupt line is asserted one cycle after any enabled bit is pending.

A small register port has a 2-bit address: 0 returns the status word (read only), 1 the mask, 2 the clear register (write only, reads zero), and 3 the pending selection packed as {valid, index}.

Top module: `irq_ctrl_unit`

## Requirements
- R1: While reset is active, and after it, the status and mask registers read zero, `irq` is low, `pend_valid` is low and `pend_idx` is zero.
- R2: A one on `evt_pulse` at a sticky position (bits 6, 7, 8, 10, 11) sets that status bit on the next clock edge. The bit stays set without further pulses. Pulses at any other position are ignored.
- R3: A write to address 2 clears each sticky status bit whose data bit is one. Zero data bits, and data bits at non-sticky positions, change nothing.
- R4: When a clear and a new pulse hit the same sticky bit in the same cycle, the bit is left set.
- R5: Each non-sticky status bit (0 to 5, 9, 12, 13, 14) equals the value its `evt_level` input had one cycle earlier. Levels at sticky positions are ignored.
- R6: A write to address 1 loads the mask. Only positions 0 to 4, 6, 7, 8, 10, 11, 12 and 14 can be set; every other mask bit reads back zero.
- R7: When status AND mask is nonzero, `pend_valid` is high and `pend_idx` is the position of its most significant set bit. Address 3 returns the same pair as {valid, index}.
- R8: When status AND mask is zero, `pend_valid` is low and `pend_idx` is zero.
- R9: `irq` equals the value `pend_valid` had one cycle earlier.
- R10: Writing zero to the mask drops `pend_valid` after the next clock edge and `irq` one edge after that, whatever the status holds.
- R11: Writes to address 0 and address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_pulse | input | 15 | One-cycle event pulses from the core; only sticky positions are used |
| evt_level | input | 15 | Level conditions from the core; only non-sticky positions are used |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 mask, 2 clear, 3 pending |
| reg_wdata | input | 15 | Register write data |
| reg_rdata | output | 15 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request, registered |
| pend_valid | output | 1 | An enabled status bit is set |
| pend_idx | output | 4 | Position of the highest enabled set bit, zero when none |

## Verification
A sticky bit that is lost or stuck shows up on the status read and in `pend_idx` at the first sample after the edge that should have changed it. Stimulus that pairs a clear with a fresh pulse, or places pulses and levels at the wrong kind of position, exposes wrong merge logic within one cycle. A fault in the mask or the priority choice shifts `pend_idx` at once whenever two enabled bits overlap. A mistimed interrupt line is visible as `irq` leading or lagging `pend_valid` by a cycle around each mask change.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

  // Register port address map
  typedef enum logic [1:0] {
    ADDR_STATUS  = 2'd0,
    ADDR_MASK    = 2'd1,
    ADDR_CLEAR   = 2'd2,
    ADDR_PENDING = 2'd3
  } reg_addr_e;

  localparam int DEF_EVT_W = 15;

  // Sticky protocol events: slave address hit 6, stop 7, arb lost 8,
  // no-acknowledge 10, repeated start 11
  localparam logic [DEF_EVT_W-1:0] DEF_STICKY_MASK = 15'h0DC0;

  // Mask bits that physically exist
  localparam logic [DEF_EVT_W-1:0] DEF_ENABLE_MASK = 15'h5DDF;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int                 EVT_W       = 15,
  parameter logic [EVT_W-1:0]   STICKY_MASK = 15'h0DC0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_pulse,
  input  logic [EVT_W-1:0] evt_level,
  input  logic             clr_en,
  input  logic [EVT_W-1:0] clr_bits,
  output logic [EVT_W-1:0] status_q
);

  logic [EVT_W-1:0] clr_vec;
  logic [EVT_W-1:0] sticky_d;
  logic [EVT_W-1:0] level_d;
  logic [EVT_W-1:0] status_d;

  // Next state: a new pulse is OR-ed in after the clear, so it wins
  always_comb begin
    clr_vec  = clr_en ? (clr_bits & STICKY_MASK) : '0;
    sticky_d = ((status_q & ~clr_vec) | evt_pulse) & STICKY_MASK;
    level_d  = evt_level & ~STICKY_MASK;
    status_d = sticky_d | level_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      status_q <= status_d;
    end
  end

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int               EVT_W       = 15,
  parameter logic [EVT_W-1:0] ENABLE_MASK = 15'h5DDF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [EVT_W-1:0] wr_data,
  output logic [EVT_W-1:0] enable_q
);

  logic [EVT_W-1:0] enable_d;

  always_comb begin
    enable_d = enable_q;
    if (wr_en) begin
      enable_d = wr_data & ENABLE_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
    end else begin
      enable_q <= enable_d;
    end
  end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int EVT_W = 15,
  parameter int IDX_W = 4
) (
  input  logic [EVT_W-1:0] req,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);

  // Highest-numbered request wins: later loop iterations overwrite
  always_comb begin
    valid = |req;
    idx   = '0;
    for (int i = 0; i < EVT_W; i++) begin
      if (req[i]) begin
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
  import irq_unit_pkg::*;
#(
  parameter int               EVT_W       = DEF_EVT_W,
  parameter logic [EVT_W-1:0] STICKY_MASK = DEF_STICKY_MASK,
  parameter logic [EVT_W-1:0] ENABLE_MASK = DEF_ENABLE_MASK,
  localparam int              IDX_W       = $clog2(EVT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_pulse,
  input  logic [EVT_W-1:0] evt_level,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [EVT_W-1:0] reg_wdata,
  output logic [EVT_W-1:0] reg_rdata,
  output logic             irq,
  output logic             pend_valid,
  output logic [IDX_W-1:0] pend_idx
);

  logic             rst_sn;
  logic             mask_wr;
  logic             clr_wr;
  logic [EVT_W-1:0] status_q;
  logic [EVT_W-1:0] enable_q;
  logic [EVT_W-1:0] active;
  logic             irq_q;
  logic             irq_d;
  reg_addr_e        addr_dec;

  irq_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sn)
  );

  always_comb begin
    addr_dec = reg_addr_e'(reg_addr);
    mask_wr  = reg_wr && (addr_dec == ADDR_MASK);
    clr_wr   = reg_wr && (addr_dec == ADDR_CLEAR);
  end

  irq_status_reg #(
    .EVT_W       (EVT_W),
    .STICKY_MASK (STICKY_MASK)
  ) u_status (
    .clk       (clk),
    .rst_n     (rst_sn),
    .evt_pulse (evt_pulse),
    .evt_level (evt_level),
    .clr_en    (clr_wr),
    .clr_bits  (reg_wdata),
    .status_q  (status_q)
  );

  irq_enable_reg #(
    .EVT_W       (EVT_W),
    .ENABLE_MASK (ENABLE_MASK)
  ) u_enable (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wr_en    (mask_wr),
    .wr_data  (reg_wdata),
    .enable_q (enable_q)
  );

  assign active = status_q & enable_q;

  irq_prio_sel #(
    .EVT_W (EVT_W),
    .IDX_W (IDX_W)
  ) u_prio (
    .req   (active),
    .valid (pend_valid),
    .idx   (pend_idx)
  );

  // Interrupt line: one register stage after the pending flag
  assign irq_d = pend_valid;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  always_comb begin
    unique case (addr_dec)
      ADDR_STATUS:  reg_rdata = status_q;
      ADDR_MASK:    reg_rdata = enable_q;
      ADDR_CLEAR:   reg_rdata = '0;
      ADDR_PENDING: reg_rdata = EVT_W'({pend_valid, pend_idx});
      default:      reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_ctrl_unit_chk.sv
module irq_ctrl_unit_chk #(
  parameter int               EVT_W       = 15,
  parameter logic [EVT_W-1:0] STICKY_MASK = 15'h0DC0,
  parameter logic [EVT_W-1:0] ENABLE_MASK = 15'h5DDF,
  parameter int               IDX_W       = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [EVT_W-1:0] evt_pulse,
  input logic [EVT_W-1:0] evt_level,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [EVT_W-1:0] reg_wdata,
  input logic [EVT_W-1:0] status_q,
  input logic [EVT_W-1:0] enable_q,
  input logic             irq,
  input logic             pend_valid,
  input logic [IDX_W-1:0] pend_idx
);

  logic [EVT_W-1:0] clr_seen;
  logic             mask_zero_wr;

  assign clr_seen     = (reg_wr && reg_addr == 2'd2) ? reg_wdata : '0;
  assign mask_zero_wr = reg_wr && reg_addr == 2'd1 && reg_wdata == '0;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q & STICKY_MASK & ~clr_seen) & ~status_q) == '0)); // R2

  AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_pulse & STICKY_MASK) & ~status_q) == '0)); // R4

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_seen & STICKY_MASK & ~evt_pulse) & status_q) == '0)); // R3

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~STICKY_MASK) == $past(evt_level & ~STICKY_MASK))); // R5

  AST_MASK_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q & ~ENABLE_MASK) == '0); // R6

  AST_TOP_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (((status_q & enable_q) >> pend_idx) == EVT_W'(1))); // R7

  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid |-> (pend_idx == '0 && (status_q & enable_q) == '0)); // R8

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |=> irq); // R9

  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid |=> !irq); // R9

  AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    mask_zero_wr |=> !pend_valid); // R10

endmodule

bind irq_ctrl_unit irq_ctrl_unit_chk #(
  .EVT_W       (EVT_W),
  .STICKY_MASK (STICKY_MASK),
  .ENABLE_MASK (ENABLE_MASK),
  .IDX_W       (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sn),
  .evt_pulse  (evt_pulse),
  .evt_level  (evt_level),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .status_q   (status_q),
  .enable_q   (enable_q),
  .irq        (irq),
  .pend_valid (pend_valid),
  .pend_idx   (pend_idx)
);

// File: tb/irq_ctrl_unit_bench.sv
module irq_ctrl_unit_bench;

  localparam int EVT_W   = 15;
  localparam int IDX_W   = 4;
  localparam int NVEC    = 13;
  localparam int VW      = 68;
  localparam int WD_LIM  = 20000;

  // {wr, addr, wdata, pulse, level, exp_status, exp_valid, exp_idx}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {1'b1, 2'd1, 15'h7FFF, 15'h0000, 15'h0000, 15'h0000, 1'b0, 4'd0},  // mask all, R8
    {1'b0, 2'd0, 15'h0000, 15'h0000, 15'h0002, 15'h0002, 1'b1, 4'd1},  // level, R5
    {1'b0, 2'd0, 15'h0000, 15'h0400, 15'h0002, 15'h0402, 1'b1, 4'd10}, // sticky, R2
    {1'b0, 2'd0, 15'h0000, 15'h0080, 15'h0002, 15'h0482, 1'b1, 4'd10}, // priority, R7
    {1'b1, 2'd2, 15'h0400, 15'h0000, 15'h0002, 15'h0082, 1'b1, 4'd7},  // clear, R3
    {1'b1, 2'd2, 15'h0080, 15'h0080, 15'h0002, 15'h0082, 1'b1, 4'd7},  // clear+pulse, R4
    {1'b1, 2'd2, 15'h0080, 15'h0000, 15'h2202, 15'h2202, 1'b1, 4'd1},  // unmasked levels, R6
    {1'b0, 2'd0, 15'h0000, 15'h0102, 15'h0000, 15'h0100, 1'b1, 4'd8},  // pulse on level bit, R2
    {1'b1, 2'd0, 15'h7FFF, 15'h0000, 15'h0000, 15'h0100, 1'b1, 4'd8},  // status write, R11
    {1'b1, 2'd2, 15'h7FFF, 15'h0000, 15'h0001, 15'h0001, 1'b1, 4'd0},  // clear on level, R3
    {1'b0, 2'd0, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 1'b0, 4'd0},  // idle, R8
    {1'b0, 2'd0, 15'h0000, 15'h0040, 15'h4000, 15'h4040, 1'b1, 4'd14}, // top bit, R7
    {1'b1, 2'd1, 15'h0000, 15'h0000, 15'h4000, 15'h4040, 1'b0, 4'd0}   // mask none, R10
  };

  logic             clk;
  logic             rst_n;
  logic [EVT_W-1:0] evt_pulse;
  logic [EVT_W-1:0] evt_level;
  logic             reg_wr;
  logic [1:0]       reg_addr;
  logic [EVT_W-1:0] reg_wdata;
  logic [EVT_W-1:0] reg_rdata;
  logic             irq;
  logic             pend_valid;
  logic [IDX_W-1:0] pend_idx;

  int n_checks;
  int n_fail;
  bit done;

  irq_ctrl_unit u_irq_ctrl_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_pulse  (evt_pulse),
    .evt_level  (evt_level),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq        (irq),
    .pend_valid (pend_valid),
    .pend_idx   (pend_idx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    reg_wr    = 1'b0;
    reg_addr  = 2'd0;
    reg_wdata = '0;
    evt_pulse = '0;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [EVT_W-1:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    evt_level = '0;
    idle_inputs();

    // Reset state, R1
    repeat (3) @(negedge clk);
    #1;
    check("R1 status", 32'(reg_rdata), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 pend_valid", 32'(pend_valid), 32'h0);
    check("R1 pend_idx", 32'(pend_idx), 32'h0);
    reg_addr = 2'd1;
    #1;
    check("R1 mask", 32'(reg_rdata), 32'h0);
    reg_addr = 2'd0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Vector table: R2 R3 R4 R5 R7 R8 R10 R11
    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      @(negedge clk);
      reg_wr    = v[67];
      reg_addr  = v[66:65];
      reg_wdata = v[64:50];
      evt_pulse = v[49:35];
      evt_level = v[34:20];
      @(negedge clk);
      idle_inputs();
      #1;
      check($sformatf("R2 R3 R4 R5 R11 status vec %0d", i), 32'(reg_rdata), 32'(v[19:5]));
      check($sformatf("R7 R8 R10 valid vec %0d", i), 32'(pend_valid), 32'(v[4]));
      check($sformatf("R7 R8 idx vec %0d", i), 32'(pend_idx), 32'(v[3:0]));
    end

    // Mask readback and interrupt timing: R6 R9 R10
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = 2'd1;
    reg_wdata = 15'h7FFF;
    @(negedge clk);
    idle_inputs();
    reg_addr = 2'd1;
    #1;
    check("R6 mask readback", 32'(reg_rdata), 32'h5DDF);
    check("R9 irq lags valid", 32'(irq), 32'h0);
    check("R7 valid", 32'(pend_valid), 32'h1);
    reg_addr = 2'd3;
    #1;
    check("R7 pending read", 32'(reg_rdata), 32'h1E);
    @(negedge clk);
    #1;
    check("R9 irq set", 32'(irq), 32'h1);
    reg_wr    = 1'b1;
    reg_addr  = 2'd3;
    reg_wdata = 15'h0000;
    @(negedge clk);
    idle_inputs();
    reg_addr = 2'd1;
    #1;
    check("R11 pending write", 32'(reg_rdata), 32'h5DDF);
    do_write(2'd1, 15'h0000);
    #1;
    check("R10 valid drops", 32'(pend_valid), 32'h0);
    check("R10 irq still high", 32'(irq), 32'h1);
    @(negedge clk);
    #1;
    check("R10 irq drops", 32'(irq), 32'h0);

    // Reset in mid-run, R1
    do_write(2'd1, 15'h7FFF);
    @(negedge clk);
    evt_pulse = 15'h0800;
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    #1;
    check("R9 irq before reset", 32'(irq), 32'h1);
    rst_n = 1'b0;
    #1;
    check("R1 irq in reset", 32'(irq), 32'h0);
    check("R1 valid in reset", 32'(pend_valid), 32'h0);
    check("R1 status in reset", 32'(reg_rdata), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WD_LIM) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WD_LIM);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule